// File: doc/BRIEF.md
# Tile Scanline Pixel Renderer

This block paints one horizontal line of a character-tile display. On a start pulse it captures a video-RAM base address, the row index inside the current tile row, and the tile stride in bytes. It then walks a row of two-byte tile pointers held in video RAM. Each pointer is combined with the per-line offset to select where the tile's pixel bytes sit in a graphics ROM, and the block plays those bytes out on an 8-bit DAC port. Each pixel is held for a fixed number of clocks. The block ends the line by driving black.

Both memories are synchronous-read with one cycle of latency. The pointer of the tile that follows is read and offset while the current tile is still on screen, so there is no seam in the pixel stream between tiles. The number of tiles per line, the pixels per tile (6 or 8) and the clocks per pixel are elaboration parameters. The row index and stride are run-time inputs, which lets the same video-RAM row serve every line of a tile row.

The sequencer moves through these states and transitions:
- IDLE goes to PTR_LO on start.
- PTR_LO, PTR_HI and PTR_JOIN read the first pointer and add the offset.
- PRIME issues the first ROM read, and LEAD loads the first pixel.
- RUN plays pixels and goes to BLANK when the last pixel of the last tile ends.
- BLANK drives black for one cycle, DONE raises the done pulse, and the block then returns to IDLE.

Top module: `tile_line_render`

## Requirements
- R1: After reset and in every cycle where busy_o is 0, pix_o is 0 and done_o is 0.
- R2: A start pulse is accepted only in IDLE, where base, row and stride are captured. Changes to those inputs afterwards, and start pulses while busy_o is 1, do not change the line being drawn and do not launch a second line.
- R3: Tile t uses ROM base P_t + row*stride, computed modulo 2^16. P_t is a 16-bit pointer whose low byte is at VRAM address base+2t and whose high byte is at base+2t+1.
- R4: The line consists of TILES tiles of TILE_PX pixels each. The pixels of one tile come from consecutive ROM addresses starting at that tile's base. The first pixel is on pix_o in the sixth cycle after the clock edge that samples start.
- R5: Each pixel is held for exactly PX_CLKS cycles, and the last pixel of one tile is followed directly by the first pixel of the next.
- R6: In the cycle right after the last pixel of the last tile, pix_o is 0.
- R7: done_o is 1 for exactly one cycle, the cycle after the black cycle. busy_o is 0 in the cycle after that.
- R8: While busy_o is 1, vram_addr_o stays within base to base+2*TILES.
- R9: Adding the offset carries from the low byte of the pointer into its high byte, and the sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start a line (accepted only when idle) |
| vram_base_i | input | VA_W | VRAM address of the first tile pointer |
| row_i | input | 3 | Row index inside the tile row (0..7) |
| stride_i | input | 8 | Bytes per tile row in ROM |
| vram_addr_o | output | VA_W | VRAM read address |
| vram_data_i | input | 8 | VRAM read data, one cycle after the address |
| rom_addr_o | output | 16 | Tile ROM read address |
| rom_data_i | input | 8 | ROM read data, one cycle after the address |
| pix_o | output | 8 | DAC pixel value |
| busy_o | output | 1 | Line in progress |
| done_o | output | 1 | One-cycle end-of-line pulse |

## Verification
The bench aims at tile seams. A design that fetches the next pointer too late shows a stale or repeated pixel, or one pixel held for a wrong number of cycles, at every tile boundary. Pointer data is chosen so that the low byte plus the offset overflows, and one row wraps past 0xFFFF. This catches a design that adds only to the low byte or swaps the byte order. The bench also moves every input and pulses start in the middle of a line: a design that re-samples its inputs or restarts would redraw from the wrong row. The black cycle, the timing of the done pulse and the range of VRAM addresses are checked as well, which exposes off-by-one errors at the end of the line and prefetches past the last entry.

// File: rtl/tile_line_pkg.sv
package tile_line_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_PTR_JOIN,
        ST_PRIME,
        ST_LEAD,
        ST_RUN,
        ST_BLANK,
        ST_DONE
    } tl_state_e;

    localparam int PTR_W = 16;
endpackage

// File: rtl/tlr_seq.sv
module tlr_seq
    import tile_line_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      line_end_i,
    output tl_state_e state_o,
    output logic      busy_o,
    output logic      done_o
);
    tl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_PTR_LO;
            ST_PTR_LO:   state_d = ST_PTR_HI;
            ST_PTR_HI:   state_d = ST_PTR_JOIN;
            ST_PTR_JOIN: state_d = ST_PRIME;
            ST_PRIME:    state_d = ST_LEAD;
            ST_LEAD:     state_d = ST_RUN;
            ST_RUN:      if (line_end_i) state_d = ST_BLANK;
            ST_BLANK:    state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o = (state_q != ST_IDLE);
        done_o = (state_q == ST_DONE);
    end

    assign state_o = state_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_after_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state_q) == ST_BLANK);
endmodule

// File: rtl/tlr_pace.sv
module tlr_pace #(
    parameter int TILES   = 40,
    parameter int TILE_PX = 6,
    parameter int PX_CLKS = 6,
    localparam int CW = $clog2(PX_CLKS),
    localparam int PW = $clog2(TILE_PX),
    localparam int TW = $clog2(TILES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    output logic          tick_o,
    output logic [PW-1:0] px_o,
    output logic [TW-1:0] tile_o
);
    logic [CW-1:0] clk_q;
    logic [PW-1:0] px_q;
    logic [TW-1:0] tile_q;

    logic clk_wrap, px_wrap, tile_last;
    assign clk_wrap  = (clk_q == CW'(PX_CLKS - 1));
    assign px_wrap   = (px_q == PW'(TILE_PX - 1));
    assign tile_last = (tile_q == TW'(TILES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q  <= '0;
            px_q   <= '0;
            tile_q <= '0;
        end else if (clear_i) begin
            clk_q  <= '0;
            px_q   <= '0;
            tile_q <= '0;
        end else if (run_i) begin
            if (clk_wrap) begin
                clk_q <= '0;
                if (px_wrap) begin
                    px_q <= '0;
                    if (!tile_last) tile_q <= tile_q + TW'(1);
                end else begin
                    px_q <= px_q + PW'(1);
                end
            end else begin
                clk_q <= clk_q + CW'(1);
            end
        end
    end

    assign tick_o = run_i && clk_wrap;
    assign px_o   = px_q;
    assign tile_o = tile_q;

    // R5
    clk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_q < CW'(PX_CLKS));

    // R4
    tile_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_q < TW'(TILES)) && (px_q < PW'(TILE_PX)));
endmodule

// File: rtl/tlr_addr.sv
module tlr_addr
    import tile_line_pkg::*;
#(
    parameter int VA_W     = 16,
    parameter int TILE_PX  = 6,
    parameter int ROW_W    = 3,
    parameter int STRIDE_W = 8,
    localparam int PW = $clog2(TILE_PX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tl_state_e           state_i,
    input  logic                start_i,
    input  logic [VA_W-1:0]     base_i,
    input  logic [ROW_W-1:0]    row_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic                tick_i,
    input  logic [PW-1:0]       px_i,
    input  logic                last_px_i,
    input  logic                last_tile_i,
    input  logic [7:0]          vram_data_i,
    output logic [VA_W-1:0]     vram_addr_o,
    output logic [PTR_W-1:0]    rom_addr_o
);
    logic [VA_W-1:0]  vptr;
    logic [PTR_W-1:0] offset;
    logic [7:0]       lo_byte;
    logic [PTR_W-1:0] nxt_ptr;
    logic [PTR_W-1:0] rom_ptr;
    logic [PTR_W-1:0] joined;

    assign joined = {vram_data_i, lo_byte} + offset;

    logic fetch_lo, fetch_hi, jump_next;
    assign fetch_lo  = tick_i && !last_tile_i && (px_i == '0);
    assign fetch_hi  = tick_i && !last_tile_i && (px_i == PW'(1));
    assign jump_next = !last_px_i && (px_i == PW'(TILE_PX - 2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vptr    <= '0;
            offset  <= '0;
            lo_byte <= '0;
            nxt_ptr <= '0;
            rom_ptr <= '0;
        end else begin
            unique case (state_i)
                ST_IDLE: begin
                    if (start_i) begin
                        vptr   <= base_i;
                        offset <= PTR_W'(row_i) * PTR_W'(stride_i);
                    end
                end
                ST_PTR_LO:   vptr <= vptr + VA_W'(1);
                ST_PTR_HI:   lo_byte <= vram_data_i;
                ST_PTR_JOIN: begin
                    rom_ptr <= joined;
                    vptr    <= vptr + VA_W'(1);
                end
                ST_LEAD:     rom_ptr <= rom_ptr + PTR_W'(1);
                ST_RUN: begin
                    if (fetch_lo) begin
                        lo_byte <= vram_data_i;
                        vptr    <= vptr + VA_W'(1);
                    end
                    if (fetch_hi) begin
                        nxt_ptr <= joined;
                        vptr    <= vptr + VA_W'(1);
                    end
                    if (tick_i) begin
                        if (jump_next) rom_ptr <= nxt_ptr;
                        else           rom_ptr <= rom_ptr + PTR_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign vram_addr_o = vptr;
    assign rom_addr_o  = rom_ptr;

    // R2
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_IDLE) |=> $stable(offset));

    // R5
    rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_RUN && !tick_i) |=> $stable(rom_ptr));
endmodule

// File: rtl/tile_line_render.sv
module tile_line_render
    import tile_line_pkg::*;
#(
    parameter int TILES    = 40,
    parameter int TILE_PX  = 6,
    parameter int PX_CLKS  = 6,
    parameter int VA_W     = 16,
    parameter int ROW_W    = 3,
    parameter int STRIDE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [VA_W-1:0]     vram_base_i,
    input  logic [ROW_W-1:0]    row_i,
    input  logic [STRIDE_W-1:0] stride_i,
    output logic [VA_W-1:0]     vram_addr_o,
    input  logic [7:0]          vram_data_i,
    output logic [15:0]         rom_addr_o,
    input  logic [7:0]          rom_data_i,
    output logic [7:0]          pix_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int PW = $clog2(TILE_PX);
    localparam int TW = $clog2(TILES);

    tl_state_e     state;
    logic          tick;
    logic [PW-1:0] px;
    logic [TW-1:0] tile;
    logic          last_px, last_tile, line_end;

    assign last_px   = (px == PW'(TILE_PX - 1));
    assign last_tile = (tile == TW'(TILES - 1));
    assign line_end  = tick && last_px && last_tile;

    tlr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .line_end_i (line_end),
        .state_o    (state),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    tlr_pace #(
        .TILES   (TILES),
        .TILE_PX (TILE_PX),
        .PX_CLKS (PX_CLKS)
    ) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state == ST_LEAD),
        .run_i   (state == ST_RUN),
        .tick_o  (tick),
        .px_o    (px),
        .tile_o  (tile)
    );

    tlr_addr #(
        .VA_W     (VA_W),
        .TILE_PX  (TILE_PX),
        .ROW_W    (ROW_W),
        .STRIDE_W (STRIDE_W)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .start_i     (start_i),
        .base_i      (vram_base_i),
        .row_i       (row_i),
        .stride_i    (stride_i),
        .tick_i      (tick),
        .px_i        (px),
        .last_px_i   (last_px),
        .last_tile_i (last_tile),
        .vram_data_i (vram_data_i),
        .vram_addr_o (vram_addr_o),
        .rom_addr_o  (rom_addr_o)
    );

    logic [7:0] pix_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= 8'h00;
        end else begin
            unique case (state)
                ST_LEAD: pix_q <= rom_data_i;
                ST_RUN:  if (tick) pix_q <= line_end ? 8'h00 : rom_data_i;
                default: pix_q <= 8'h00;
            endcase
        end
    end

    assign pix_o = pix_q;

    // R1
    idle_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (pix_o == 8'h00 && !done_o));

    // R6
    black_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(pix_o) == 8'h00);
endmodule

// File: tb/tile_line_render_bench.sv
module tile_line_render_bench;
    localparam int TILES   = 40;
    localparam int TILE_PX = 6;
    localparam int PX_CLKS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] vram_base_i = '0;
    logic [2:0]  row_i = '0;
    logic [7:0]  stride_i = '0;
    logic [15:0] vram_addr_o;
    logic [7:0]  vram_data_i;
    logic [15:0] rom_addr_o;
    logic [7:0]  rom_data_i;
    logic [7:0]  pix_o;
    logic        busy_o, done_o;

    always #4 clk = ~clk;

    tile_line_render u_tile_line_render (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vram_base_i(vram_base_i),
        .row_i(row_i), .stride_i(stride_i), .vram_addr_o(vram_addr_o),
        .vram_data_i(vram_data_i), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
        .pix_o(pix_o), .busy_o(busy_o), .done_o(done_o)
    );

    logic [7:0] vmem [0:1023];

    function automatic logic [7:0] romf(input logic [15:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd7;
        return m ^ a[15:8] ^ 8'h3C;
    endfunction

    always_ff @(posedge clk) begin
        vram_data_i <= vmem[vram_addr_o[9:0]];
        rom_data_i  <= romf(rom_addr_o);
    end

    int checks = 0;
    int fails = 0;
    int lines_done = 0;
    logic [7:0] exp_q [$];
    logic [15:0] cur_base = '0;
    logic range_bad = 1'b0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (busy_o && (vram_addr_o < cur_base ||
                       vram_addr_o > cur_base + 16'(2 * TILES)))
            range_bad = 1'b1;
    end

    task automatic fill_row(input int base, input logic [15:0] seed);
        for (int t = 0; t < TILES; t++) begin
            logic [15:0] p;
            p = seed + 16'(t * 263);
            vmem[base + 2 * t]     = p[7:0];
            vmem[base + 2 * t + 1] = p[15:8];
        end
    endtask

    // driver: pushes expected pixels, then launches the line
    task automatic run_line(input int base, input logic [2:0] row,
                            input logic [7:0] stride, input bit poke);
        int target;
        for (int t = 0; t < TILES; t++) begin
            logic [15:0] p;
            p = {vmem[base + 2 * t + 1], vmem[base + 2 * t]} + 16'(row) * 16'(stride);
            for (int k = 0; k < TILE_PX; k++) exp_q.push_back(romf(p + 16'(k)));
        end
        exp_q.push_back(8'h00);
        target = lines_done + 1;
        range_bad = 1'b0;
        cur_base = 16'(base);
        @(negedge clk);
        vram_base_i = 16'(base); row_i = row; stride_i = stride; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R2: scramble inputs right after capture
        vram_base_i = 16'h0000; row_i = ~row; stride_i = stride + 8'd3;
        if (poke) begin
            repeat (300) @(negedge clk);
            start_i = 1'b1; vram_base_i = 16'h0080; row_i = 3'd5;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (lines_done < target) @(negedge clk);
        chk("R8 vram range", {31'd0, range_bad}, 32'd0);
        repeat (4) begin
            @(negedge clk);
            chk("R1 R2 idle after line", {22'd0, pix_o, busy_o, done_o}, 32'd0);
        end
    endtask

    // monitor: pops expected items as pixels appear
    initial begin
        logic [7:0] e, got;
        bit bad;
        forever begin
            @(negedge clk);
            if (busy_o) begin
                repeat (5) @(negedge clk);
                while (exp_q.size() > 1) begin
                    e = exp_q.pop_front();
                    bad = 1'b0; got = e;
                    for (int k = 0; k < PX_CLKS; k++) begin
                        if (pix_o !== e && !bad) begin bad = 1'b1; got = pix_o; end
                        if (k < PX_CLKS - 1) @(negedge clk);
                    end
                    chk("R3 R4 R5 R9 pixel", {24'd0, got}, {24'd0, e});
                    @(negedge clk);
                end
                e = exp_q.pop_front();
                chk("R6 black", {24'd0, pix_o}, {24'd0, e});
                chk("R7 no done in black cycle", {31'd0, done_o}, 32'd0);
                @(negedge clk);
                chk("R7 done pulse", {31'd0, done_o}, 32'd1);
                @(negedge clk);
                chk("R7 done drops, idle", {30'd0, done_o, busy_o}, 32'd0);
                lines_done++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) vmem[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R1 reset pix", {24'd0, pix_o}, 32'd0);
        chk("R1 reset flags", {30'd0, busy_o, done_o}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", {22'd0, pix_o, busy_o, done_o}, 32'd0);

        fill_row(16'h040, 16'h1000);
        run_line(16'h040, 3'd0, 8'd6, 1'b0);
        fill_row(16'h200, 16'h20F8);
        run_line(16'h200, 3'd7, 8'd6, 1'b0);
        fill_row(16'h300, 16'hFFE0);
        run_line(16'h300, 3'd3, 8'd8, 1'b1);
        run_line(16'h040, 3'd2, 8'd6, 1'b0);
        run_line(16'h200, 3'd5, 8'd8, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule